// File: doc/BRIEF.md
# Management-Bus PHY Discovery Scanner

This sequencer locates the first Ethernet PHY that answers on an MDIO management bus and captures its 32-bit identifier. It does not drive the management wires. It hands register-read requests to a separate MDIO master through a valid/ready request port. It then waits for a one-cycle done pulse that carries the 16 bits read back.

A pulse on `start` clears the previous result and begins a search. The scanner probes bus addresses in ascending order and reads the first identifier register at each one. The all-ones value marks an empty address. At the first address that answers, a second read collects the low identifier half, and the search ends with `found` set. If a full sweep finds nothing, the scanner waits a programmable recovery time so that slow PHYs can come out of reset. It then sweeps again, up to a fixed number of sweeps. After that it reports `notFound`.

Top module: `phy_scan_top`

## Requirements
- R1: After an accepted start, the first request (address 0) is presented in the very next cycle. Addresses are probed strictly in ascending order 0..2^ADDR_W-1, and the first sweep has no wait before it.
- R2: A presence probe reads register 2. An address counts as occupied when that read returns any value other than 0xFFFF, including 0xFFFE.
- R3: At an occupied address, register 3 is read at the same address. phyId becomes {register 2 value in bits 31:16, register 3 value in bits 15:0}, phyAddr shows the address and found is set. Any register 3 value, including 0xFFFF, is accepted.
- R4: The search stops at the first occupied address. No request follows the register 3 read, and the result holds until the next accepted start.
- R5: At most PASS_MAX sweeps (default 11) are made. When the last one ends empty, notFound is set while phyAddr and phyId read zero.
- R6: Between sweeps no request is issued. The address-0 request of the next sweep appears WAIT_CYCLES+1 cycles after the cycle in which the address-31 response arrived.
- R7: reqValid stays high with reqAddr and reqReg stable until reqReady is seen. Only one request is outstanding at a time. rspDone is ignored unless a response is awaited.
- R8: busy is high from the cycle after an accepted start until found or notFound is set. The three are mutually exclusive, and a start while busy is ignored.
- R9: An accepted start clears found, notFound, phyAddr and phyId in the following cycle.
- R10: After reset, busy, found, notFound and reqValid are low, and phyAddr and phyId are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new search (ignored while busy) |
| reqValid | output | 1 | Read request valid |
| reqReady | input | 1 | MDIO master accepts the request |
| reqAddr | output | ADDR_W | PHY bus address of the request |
| reqReg | output | 5 | Register number of the request (2 or 3) |
| rspDone | input | 1 | One-cycle pulse: read data valid |
| rspData | input | DATA_W | Data returned by the read |
| busy | output | 1 | Search in progress |
| found | output | 1 | A PHY was found |
| notFound | output | 1 | All sweeps ended empty |
| phyAddr | output | ADDR_W | Address of the found PHY, zero otherwise |
| phyId | output | 2*DATA_W | Captured identifier, zero unless found |

## Verification
A behavioural responder answers reads with a set response latency. It can place a PHY at an address and make it answer only from a given sweep onward. PHYs at address 5, at 0 and at 31 cover the ordinary case and both ends of the range. The address-0 run also returns 0xFFFE/0xFFFF, which separates the sentinel test on the first read from any test on the second. A PHY that first answers in sweep 3 checks sweep counting and the exact recovery gap, and an empty bus checks the sweep limit and the cleared result. A stalled request port with stray done pulses, and a start pulse in the middle of a scan, check that the handshake and the ignore rules hold, because a wrongly taken pulse breaks the ascending address order.

// File: rtl/phy_scan_pkg.sv
package phy_scan_pkg;

  localparam int REG_W = 5;
  localparam logic [REG_W-1:0] ID1_REG = 5'd2;
  localparam logic [REG_W-1:0] ID2_REG = 5'd3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ASK1,
    S_HEAR1,
    S_GAP,
    S_ASK2,
    S_HEAR2
  } scanStateT;

  // control -> datapath
  typedef struct packed {
    logic clrAll;
    logic clrAddr;
    logic incAddr;
    logic incPass;
    logic clrDelay;
    logic incDelay;
    logic ldHi;
    logic ldLo;
    logic setFound;
    logic setNone;
  } scanStrobeT;

  // datapath -> control
  typedef struct packed {
    logic lastAddr;
    logic lastPass;
    logic delayDone;
    logic absent;
  } scanStatusT;

endpackage

// File: rtl/phy_scan_ctrl.sv
module phy_scan_ctrl
  import phy_scan_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       reqReady,
  input  logic       rspDone,
  input  scanStatusT stat,
  output scanStrobeT stb,
  output logic       reqValid,
  output logic       regSel,
  output logic       busy
);

  scanStateT state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    reqValid  = 1'b0;
    regSel    = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          stb.clrAll = 1'b1;
          nextState  = S_ASK1;
        end
      end
      S_ASK1: begin
        reqValid = 1'b1;
        if (reqReady) nextState = S_HEAR1;
      end
      S_HEAR1: begin
        if (rspDone) begin
          if (!stat.absent) begin
            stb.ldHi  = 1'b1;
            nextState = S_ASK2;
          end else if (!stat.lastAddr) begin
            stb.incAddr = 1'b1;
            nextState   = S_ASK1;
          end else if (!stat.lastPass) begin
            stb.clrDelay = 1'b1;
            nextState    = S_GAP;
          end else begin
            stb.setNone = 1'b1;
            nextState   = S_IDLE;
          end
        end
      end
      S_GAP: begin
        stb.incDelay = 1'b1;
        if (stat.delayDone) begin
          stb.clrAddr = 1'b1;
          stb.incPass = 1'b1;
          nextState   = S_ASK1;
        end
      end
      S_ASK2: begin
        reqValid = 1'b1;
        regSel   = 1'b1;
        if (reqReady) nextState = S_HEAR2;
      end
      S_HEAR2: begin
        if (rspDone) begin
          stb.ldLo     = 1'b1;
          stb.setFound = 1'b1;
          nextState    = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/phy_scan_dp.sv
module phy_scan_dp
  import phy_scan_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 16,
  parameter int PASS_MAX    = 11,
  parameter int WAIT_CYCLES = 1000000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  scanStrobeT            stb,
  input  logic                  regSel,
  input  logic [DATA_W-1:0]     rspData,
  output scanStatusT            stat,
  output logic [ADDR_W-1:0]     reqAddr,
  output logic [REG_W-1:0]      reqReg,
  output logic                  found,
  output logic                  notFound,
  output logic [ADDR_W-1:0]     phyAddr,
  output logic [2*DATA_W-1:0]   phyId
);

  localparam int NUM_ADDR = 1 << ADDR_W;
  localparam int PASS_W   = $clog2(PASS_MAX + 1);
  localparam int DLY_W    = $clog2(WAIT_CYCLES + 1);

  logic [ADDR_W-1:0] curAddr;
  logic [PASS_W-1:0] passCnt;
  logic [DLY_W-1:0]  delayCnt;
  logic [DATA_W-1:0] idHi, idLo;
  logic              foundQ, noneQ;

  always_ff @(posedge clk) begin
    if (!rstN || stb.clrAll || stb.clrAddr) curAddr <= '0;
    else if (stb.incAddr)                   curAddr <= curAddr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clrAll) passCnt <= PASS_W'(1);
    else if (stb.incPass)    passCnt <= passCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clrAll || stb.clrDelay) delayCnt <= '0;
    else if (stb.incDelay)                   delayCnt <= delayCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clrAll) begin
      idHi   <= '0;
      idLo   <= '0;
      foundQ <= 1'b0;
      noneQ  <= 1'b0;
    end else begin
      if (stb.ldHi)     idHi   <= rspData;
      if (stb.ldLo)     idLo   <= rspData;
      if (stb.setFound) foundQ <= 1'b1;
      if (stb.setNone)  noneQ  <= 1'b1;
    end
  end

  assign stat.lastAddr  = (curAddr == ADDR_W'(NUM_ADDR - 1));
  assign stat.lastPass  = (passCnt == PASS_W'(PASS_MAX));
  assign stat.delayDone = (delayCnt == DLY_W'(WAIT_CYCLES - 1));
  assign stat.absent    = (rspData == {DATA_W{1'b1}});

  assign reqAddr  = curAddr;
  assign reqReg   = regSel ? ID2_REG : ID1_REG;
  assign found    = foundQ;
  assign notFound = noneQ;
  assign phyAddr  = foundQ ? curAddr : '0;
  assign phyId    = {idHi, idLo};

endmodule

// File: rtl/phy_scan_top.sv
module phy_scan_top
  import phy_scan_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 16,
  parameter int PASS_MAX    = 11,
  parameter int WAIT_CYCLES = 1000000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  output logic                reqValid,
  input  logic                reqReady,
  output logic [ADDR_W-1:0]   reqAddr,
  output logic [4:0]          reqReg,
  input  logic                rspDone,
  input  logic [DATA_W-1:0]   rspData,
  output logic                busy,
  output logic                found,
  output logic                notFound,
  output logic [ADDR_W-1:0]   phyAddr,
  output logic [2*DATA_W-1:0] phyId
);

  scanStrobeT stb;
  scanStatusT stat;
  logic       regSel;

  phy_scan_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .reqReady (reqReady),
    .rspDone  (rspDone),
    .stat     (stat),
    .stb      (stb),
    .reqValid (reqValid),
    .regSel   (regSel),
    .busy     (busy)
  );

  phy_scan_dp #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .PASS_MAX    (PASS_MAX),
    .WAIT_CYCLES (WAIT_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .regSel   (regSel),
    .rspData  (rspData),
    .stat     (stat),
    .reqAddr  (reqAddr),
    .reqReg   (reqReg),
    .found    (found),
    .notFound (notFound),
    .phyAddr  (phyAddr),
    .phyId    (phyId)
  );

endmodule

// File: rtl/phy_scan_checker.sv
module phy_scan_checker
  import phy_scan_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic                reqValid,
  input logic                reqReady,
  input logic [ADDR_W-1:0]   reqAddr,
  input logic [4:0]          reqReg,
  input logic                busy,
  input logic                found,
  input logic                notFound,
  input logic [ADDR_W-1:0]   phyAddr,
  input logic [2*DATA_W-1:0] phyId
);

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable(reqAddr) && $stable(reqReg));

  p_req_reg_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqReg == ID1_REG) || (reqReg == ID2_REG));

  p_status_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busy, found, notFound}));

  p_req_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> busy);

  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busy && start |=> busy && !found && !notFound && (phyId == '0) && (phyAddr == '0));

  p_none_invalid_r5: assert property (@(posedge clk) disable iff (!rstN)
    notFound |-> (phyAddr == '0) && (phyId == '0));

  p_id_present_r3: assert property (@(posedge clk) disable iff (!rstN)
    found |-> (phyId[2*DATA_W-1:DATA_W] != {DATA_W{1'b1}}));

  p_result_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (found || notFound) && !start |=> (found == $past(found)) && (notFound == $past(notFound))
      && $stable(phyAddr) && $stable(phyId) && !reqValid);

endmodule

bind phy_scan_top phy_scan_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqAddr  (reqAddr),
  .reqReg   (reqReg),
  .busy     (busy),
  .found    (found),
  .notFound (notFound),
  .phyAddr  (phyAddr),
  .phyId    (phyId)
);

// File: tb/phy_scan_top_bench.sv
`timescale 1ns/1ps
module phy_scan_top_bench;

  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam int PASSES = 11;
  localparam int WAITC  = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic reqValid, reqReady = 1'b0;
  logic [ADDR_W-1:0] reqAddr;
  logic [4:0] reqReg;
  logic rspDone = 1'b0;
  logic [DATA_W-1:0] rspData = '0;
  logic busy, found, notFound;
  logic [ADDR_W-1:0] phyAddr;
  logic [2*DATA_W-1:0] phyId;

  always #2.5 clk = ~clk;

  phy_scan_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PASS_MAX(PASSES), .WAIT_CYCLES(WAITC)) u_phy_scan_top (
    .clk(clk), .rstN(rstN), .start(start), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqReg(reqReg), .rspDone(rspDone), .rspData(rspData),
    .busy(busy), .found(found), .notFound(notFound), .phyAddr(phyAddr), .phyId(phyId));

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // responder model state
  int phyAt = -1, appearPass = 1, latency = 2, modelPass = 0;
  bit stall = 0, strayArm = 0;
  logic [15:0] id1v = '0, id2v = '0;
  int reqCount = 0, expAddr = 0, orderErr = 0, capAddr = 0, capReg = 0;
  int pending = 0, cyc = 0, last31Done = -1, gap = -1, strays = 0;
  logic [15:0] respVal = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      rspDone = 1'b0;
      if (pending > 0) begin
        pending--;
        if (pending == 0) begin
          rspDone = 1'b1;
          rspData = respVal;
          if (capAddr == 31 && capReg == 2) last31Done = cyc;
        end
      end
      reqReady = stall ? (cyc % 3 == 0) : 1'b1;
      if (strayArm && pending == 0 && !rspDone && reqValid && !reqReady) begin
        rspDone = 1'b1;
        rspData = 16'h0000;
        strays++;
      end
      if (reqValid && reqAddr == 0 && reqReg == 2 && last31Done > 0 && gap < 0)
        gap = cyc - last31Done;
      if (reqValid && reqReady) begin
        reqCount++;
        capAddr = int'(reqAddr);
        capReg  = int'(reqReg);
        if (reqReg == 5'd2) begin
          if (capAddr != expAddr) orderErr++;
          expAddr = (capAddr + 1) % 32;
          if (capAddr == 0) modelPass++;
          respVal = (capAddr == phyAt && modelPass >= appearPass) ? id1v : 16'hFFFF;
        end else begin
          if (reqReg != 5'd3 || capAddr != phyAt) orderErr++;
          respVal = id2v;
        end
        pending = latency;
      end
    end
  end

  task automatic launch(input int at, input int appear, input logic [15:0] a, input logic [15:0] b,
                        input int lat, input bit st);
    phyAt = at; appearPass = appear; id1v = a; id2v = b; latency = lat; stall = st;
    modelPass = 0; reqCount = 0; expAddr = 0; orderErr = 0; last31Done = -1; gap = -1; strays = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8", busy, 1, "busy after start");
    chk("R1", {reqValid, 3'b0, reqAddr}, {1'b1, 3'b0, 5'd0}, "first request addr 0");
    chk("R9", {found, notFound, phyId}, '0, "result cleared");
  endtask

  task automatic finish_wait();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10", {busy, found, notFound, reqValid}, '0, "flags after reset");
    chk("R10", {phyAddr, phyId[26:0]}, '0, "addr/id after reset");
  endtask

  task automatic t_mid();
    launch(5, 1, 16'h0022, 16'h5611, 2, 0);
    finish_wait();
    chk("R3", {found, notFound, busy}, 3'b100, "found flag");
    chk("R3", phyAddr, 5, "phyAddr");
    chk("R3", phyId, 32'h0022_5611, "phyId");
    chk("R4", reqCount, 7, "request count stops at first");
    chk("R1", orderErr, 0, "ascending order");
  endtask

  task automatic t_addr0();
    launch(0, 1, 16'hFFFE, 16'hFFFF, 1, 1);
    finish_wait();
    chk("R2", {found, phyAddr}, {1'b1, 5'd0}, "0xFFFE counts present at addr 0");
    chk("R3", phyId, 32'hFFFE_FFFF, "phyId with all-ones low half");
    chk("R7", reqCount, 2, "requests with stalled port");
  endtask

  task automatic t_addr31();
    launch(31, 1, 16'h0181, 16'hB880, 4, 0);
    finish_wait();
    chk("R3", {found, phyAddr}, {1'b1, 5'd31}, "found at addr 31");
    chk("R3", phyId, 32'h0181_B880, "phyId at 31");
    chk("R1", {orderErr, reqCount}, {32'd0, 32'd33}, "order/count to 31");
  endtask

  task automatic t_late();
    launch(9, 3, 16'h7810, 16'h0003, 2, 0);
    finish_wait();
    chk("R6", gap, WAITC + 1, "recovery gap between sweeps");
    chk("R5", modelPass, 3, "sweep count");
    chk("R4", reqCount, 75, "requests over three sweeps");
    chk("R3", {found, phyAddr, phyId}, {1'b1, 5'd9, 32'h7810_0003}, "late result");
  endtask

  task automatic t_none();
    launch(-1, 1, 16'h0, 16'h0, 1, 0);
    finish_wait();
    chk("R5", {found, notFound, busy}, 3'b010, "notFound flag");
    chk("R5", {phyAddr, phyId[26:0]}, '0, "addr/id invalid");
    chk("R5", reqCount, PASSES * 32, "total probes");
    chk("R5", modelPass, PASSES, "sweep limit");
    chk("R6", gap, WAITC + 1, "first gap on empty bus");
  endtask

  task automatic t_busy_start();
    strayArm = 1;
    launch(20, 1, 16'h0016, 16'hF880, 2, 1);
    repeat (12) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8", busy, 1, "still busy after start while busy");
    finish_wait();
    strayArm = 0;
    chk("R7", (strays > 0), 1, "stray done pulses were injected");
    chk("R8", {orderErr, reqCount}, {32'd0, 32'd22}, "start while busy ignored");
    chk("R7", {found, phyAddr, phyId}, {1'b1, 5'd20, 32'h0016_F880}, "stray done ignored");
  endtask

  task automatic t_restart();
    launch(7, 1, 16'h02A8, 16'h0154, 3, 0);
    chk("R9", phyAddr, 0, "phyAddr cleared on restart");
    finish_wait();
    chk("R9", {found, phyAddr, phyId}, {1'b1, 5'd7, 32'h02A8_0154}, "restart result");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_mid();
    t_addr0();
    t_addr31();
    t_late();
    t_none();
    t_busy_start();
    t_restart();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule